// File: doc/BRIEF.md
# Auto-Increment Word Program Sequencer

This block sits on the host side of an SPI serial flash and writes a run of 16-bit words into it using the flash's auto-address-increment word programming mode. The host gives it a start address, a word count and a stream of words over a valid/ready handshake. The sequencer then drives the whole command protocol on one SPI master port. It sets the write-enable latch, sends one program frame per word, and waits for each internal program to finish. At the end it sends the exit command. It reports completion with a one-cycle `done` pulse, and `fail` marks the pulse of a job that was rejected or that timed out.

Completion of each word is detected in one of two ways, chosen for each job. In status-polling mode the sequencer reads the status register until its busy bit clears. In ready-output mode it first switches the flash's data-out pin into a ready/busy indicator. After each word it holds chip select low without clocking and waits for the pin to go high. A programmable limit bounds the wait in both modes. When the limit runs out, the sequencer leaves programming mode and signals an error.

The serialisation uses SPI mode 0. The clock idles low, MOSI changes while SCK is low, MISO is sampled on the rising SCK edge, and each byte goes out MSB first. Every SCK period takes two system clocks.

Top module: `aai_word_prog`

## Requirements
- R1: A start request whose address has bit 0 set, or whose word count is zero, ends on the next clock with `done` and `fail` both high. Chip select is never asserted and no word is taken.
- R2: A valid job sends write-enable (opcode 06h) as its own frame before the first program frame. In ready-output mode a frame with opcode 70h comes first, ahead of write-enable.
- R3: The first program frame is opcode ADh, then the address (bits 23:16, 15:8, 7:0), then the word's high byte and then its low byte. Each later word uses a frame of ADh and the two data bytes only. Consecutive words land at consecutive even byte addresses, with the high byte at the even address.
- R4: In status-polling mode no program frame starts while the flash is busy. Busy is read with opcode 05h, one status byte per frame, from bit 0 of that byte (1 = busy).
- R5: In ready-output mode no status-read frames are sent. After each program frame the sequencer holds chip select low without clocking until MISO reads 1.
- R6: After the last word completes, the sequencer sends a frame with opcode 04h. In ready-output mode it then sends a frame with opcode 80h. It then pulses `done` with `fail` low, and the flash's enable latch, programming mode and ready output are all cleared.
- R7: If busy is still set after `pollLimit` consecutive polls, the sequencer stops programming and sends the exit frames of R6 (04h, then 80h in ready-output mode). It then pulses `done` with `fail` high. A poll is one status frame in status-polling mode and one clock cycle in ready-output mode.
- R8: SCK is low whenever chip select is high, and SCK rises only while chip select is low.
- R9: The sequencer takes exactly one word per program frame. It raises `wordReady` only while waiting for a word and drops it for at least one cycle after each handshake.
- R10: `busy` is high from the cycle after an accepted start until `done` is high. `done` lasts one cycle, and `busy` is low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start request, sampled while idle |
| startAddr | input | 24 | First byte address, must be even |
| wordCount | input | CNT_W | Number of 16-bit words to program |
| hwReady | input | 1 | 1 = ready-output mode, 0 = status-polling mode |
| pollLimit | input | POLL_W | Maximum consecutive busy polls per word |
| wordData | input | 16 | Word to program |
| wordValid | input | 1 | wordData is valid |
| wordReady | output | 1 | Sequencer accepts a word this cycle |
| sck | output | 1 | SPI clock, mode 0 |
| csN | output | 1 | SPI chip select, active low |
| mosi | output | 1 | SPI data to flash |
| miso | input | 1 | SPI data from flash, or ready/busy |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | With done: job rejected or timed out |

## Verification
The bench drives a behavioural flash that decodes every frame, keeps its enable latch, programming mode, ready-output flag and a busy timer, and flags any protocol misuse. Random jobs mix both completion modes, word counts from 1 to 12, random even addresses, random busy lengths and random gaps in `wordValid`. These jobs test the address and data ordering against the flash's memory image and the handshake against the count of words taken. Directed jobs cover an odd address and a zero count, which must produce no bus activity. They also cover a busy time of zero in ready-output mode, where the wait must end at once. A flash that never finishes tests the timeout in both modes: in polling mode the number of status frames must equal the limit exactly.

// File: rtl/aai_pkg.sv
package aai_pkg;

  localparam int ADDR_W = 24;
  localparam int WORD_W = 16;

  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_PROG = 8'hAD;
  localparam logic [7:0] OP_STAT = 8'h05;
  localparam logic [7:0] OP_RYON = 8'h70;
  localparam logic [7:0] OP_RYOFF = 8'h80;

  typedef enum logic [2:0] {
    FR_RYON, FR_WREN, FR_PROGA, FR_PROGD, FR_STAT, FR_WRDI, FR_RYOFF
  } frameT;

  typedef struct packed {
    logic csLow;
    logic csHigh;
    logic sendByte;
    logic loadJob;
    logic captureWord;
    logic decWord;
    logic clrPoll;
    logic incPoll;
    frameT frm;
    logic [2:0] byteIdx;
  } dpCtrlT;

  function automatic logic [2:0] frameBytes(input frameT f);
    case (f)
      FR_PROGA: return 3'd6;
      FR_PROGD: return 3'd3;
      FR_STAT:  return 3'd2;
      default:  return 3'd1;
    endcase
  endfunction

endpackage

// File: rtl/aai_datapath.sv
module aai_datapath
  import aai_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int POLL_W = 16
) (
  input  logic clk,
  input  logic rstN,
  input  dpCtrlT ctl,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [CNT_W-1:0] wordCount,
  input  logic [POLL_W-1:0] pollLimit,
  input  logic [WORD_W-1:0] wordData,
  input  logic miso,
  output logic sck,
  output logic csN,
  output logic mosi,
  output logic byteDone,
  output logic rxBusy,
  output logic wordsLeftZero,
  output logic pollExhausted
);

  localparam int BIT_W = 3;

  logic [ADDR_W-1:0] addrQ;
  logic [WORD_W-1:0] wordQ;
  logic [CNT_W-1:0] wordsLeft;
  logic [POLL_W-1:0] pollCnt, limitQ;
  logic [7:0] shReg, rxReg, txByte;
  logic [BIT_W-1:0] bitCnt;
  logic phaseHigh, active;

  always_comb begin
    txByte = 8'h00;
    case (ctl.frm)
      FR_RYON:  txByte = OP_RYON;
      FR_WREN:  txByte = OP_WREN;
      FR_WRDI:  txByte = OP_WRDI;
      FR_RYOFF: txByte = OP_RYOFF;
      FR_STAT:  txByte = (ctl.byteIdx == 3'd0) ? OP_STAT : 8'h00;
      FR_PROGA:
        case (ctl.byteIdx)
          3'd0: txByte = OP_PROG;
          3'd1: txByte = addrQ[23:16];
          3'd2: txByte = addrQ[15:8];
          3'd3: txByte = addrQ[7:0];
          3'd4: txByte = wordQ[15:8];
          default: txByte = wordQ[7:0];
        endcase
      FR_PROGD:
        case (ctl.byteIdx)
          3'd0: txByte = OP_PROG;
          3'd1: txByte = wordQ[15:8];
          default: txByte = wordQ[7:0];
        endcase
      default: txByte = 8'h00;
    endcase
  end

  // job registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      wordQ <= '0;
      wordsLeft <= '0;
      limitQ <= '0;
      pollCnt <= '0;
    end else begin
      if (ctl.loadJob) begin
        addrQ <= startAddr;
        wordsLeft <= wordCount;
        limitQ <= pollLimit;
      end
      if (ctl.captureWord) wordQ <= wordData;
      if (ctl.decWord) wordsLeft <= wordsLeft - CNT_W'(1);
      if (ctl.clrPoll) pollCnt <= '0;
      else if (ctl.incPoll) pollCnt <= pollCnt + POLL_W'(1);
    end
  end

  // byte shifter, mode 0, two system clocks per SCK period
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg <= '0;
      rxReg <= '0;
      bitCnt <= '0;
      phaseHigh <= 1'b0;
      active <= 1'b0;
      sck <= 1'b0;
      byteDone <= 1'b0;
    end else begin
      byteDone <= 1'b0;
      if (ctl.sendByte) begin
        shReg <= txByte;
        active <= 1'b1;
        bitCnt <= '0;
        phaseHigh <= 1'b0;
      end else if (active) begin
        if (!phaseHigh) begin
          sck <= 1'b1;
          rxReg <= {rxReg[6:0], miso};
          phaseHigh <= 1'b1;
        end else begin
          sck <= 1'b0;
          phaseHigh <= 1'b0;
          if (bitCnt == BIT_W'(7)) begin
            active <= 1'b0;
            byteDone <= 1'b1;
          end else begin
            bitCnt <= bitCnt + BIT_W'(1);
            shReg <= {shReg[6:0], 1'b0};
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) csN <= 1'b1;
    else if (ctl.csLow) csN <= 1'b0;
    else if (ctl.csHigh) csN <= 1'b1;
  end

  assign mosi = shReg[7];
  assign rxBusy = rxReg[0];
  assign wordsLeftZero = (wordsLeft == '0);
  assign pollExhausted = ({1'b0, pollCnt} + (POLL_W+1)'(1)) >= {1'b0, limitQ};

endmodule

// File: rtl/aai_control.sv
module aai_control
  import aai_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic start,
  input  logic hwReady,
  input  logic addrOdd,
  input  logic countZero,
  input  logic wordValid,
  input  logic miso,
  input  logic byteDone,
  input  logic rxBusy,
  input  logic wordsLeftZero,
  input  logic pollExhausted,
  output dpCtrlT ctl,
  output logic wordReady,
  output logic busy,
  output logic done,
  output logic fail
);

  typedef enum logic [3:0] {
    ST_IDLE, ST_OPEN, ST_SEND, ST_WAITB, ST_CLOSE,
    ST_NEXT, ST_FETCH, ST_HWWAIT, ST_DONE
  } stateT;

  stateT state, stateN;
  frameT frm, frmN;
  logic [2:0] byteIdx, idxN;
  logic hwMode, hwN, firstWord, firstN, errQ, errN;

  always_comb begin
    ctl = '0;
    ctl.frm = frm;
    ctl.byteIdx = byteIdx;
    stateN = state;
    frmN = frm;
    idxN = byteIdx;
    hwN = hwMode;
    firstN = firstWord;
    errN = errQ;
    wordReady = 1'b0;
    case (state)
      ST_IDLE:
        if (start) begin
          if (addrOdd || countZero) begin
            errN = 1'b1;
            stateN = ST_DONE;
          end else begin
            ctl.loadJob = 1'b1;
            errN = 1'b0;
            hwN = hwReady;
            firstN = 1'b1;
            frmN = hwReady ? FR_RYON : FR_WREN;
            idxN = 3'd0;
            stateN = ST_OPEN;
          end
        end
      ST_OPEN: begin
        ctl.csLow = 1'b1;
        stateN = ST_SEND;
      end
      ST_SEND: begin
        ctl.sendByte = 1'b1;
        stateN = ST_WAITB;
      end
      ST_WAITB:
        if (byteDone) begin
          if (byteIdx == frameBytes(frm) - 3'd1) stateN = ST_CLOSE;
          else begin
            idxN = byteIdx + 3'd1;
            stateN = ST_SEND;
          end
        end
      ST_CLOSE: begin
        ctl.csHigh = 1'b1;
        stateN = ST_NEXT;
      end
      ST_NEXT: begin
        idxN = 3'd0;
        case (frm)
          FR_RYON: begin
            frmN = FR_WREN;
            stateN = ST_OPEN;
          end
          FR_WREN: stateN = ST_FETCH;
          FR_PROGA, FR_PROGD: begin
            ctl.decWord = 1'b1;
            ctl.clrPoll = 1'b1;
            if (hwMode) begin
              ctl.csLow = 1'b1;
              stateN = ST_HWWAIT;
            end else begin
              frmN = FR_STAT;
              stateN = ST_OPEN;
            end
          end
          FR_STAT:
            if (!rxBusy) begin
              if (wordsLeftZero) begin
                frmN = FR_WRDI;
                stateN = ST_OPEN;
              end else stateN = ST_FETCH;
            end else if (pollExhausted) begin
              errN = 1'b1;
              frmN = FR_WRDI;
              stateN = ST_OPEN;
            end else begin
              ctl.incPoll = 1'b1;
              stateN = ST_OPEN;
            end
          FR_WRDI:
            if (hwMode) begin
              frmN = FR_RYOFF;
              stateN = ST_OPEN;
            end else stateN = ST_DONE;
          default: stateN = ST_DONE;
        endcase
      end
      ST_FETCH: begin
        wordReady = 1'b1;
        if (wordValid) begin
          ctl.captureWord = 1'b1;
          frmN = firstWord ? FR_PROGA : FR_PROGD;
          firstN = 1'b0;
          idxN = 3'd0;
          stateN = ST_OPEN;
        end
      end
      ST_HWWAIT:
        if (miso) begin
          ctl.csHigh = 1'b1;
          if (wordsLeftZero) begin
            frmN = FR_WRDI;
            idxN = 3'd0;
            stateN = ST_OPEN;
          end else stateN = ST_FETCH;
        end else if (pollExhausted) begin
          ctl.csHigh = 1'b1;
          errN = 1'b1;
          frmN = FR_WRDI;
          idxN = 3'd0;
          stateN = ST_OPEN;
        end else ctl.incPoll = 1'b1;
      ST_DONE: stateN = ST_IDLE;
      default: stateN = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      frm <= FR_WREN;
      byteIdx <= '0;
      hwMode <= 1'b0;
      firstWord <= 1'b0;
      errQ <= 1'b0;
    end else begin
      state <= stateN;
      frm <= frmN;
      byteIdx <= idxN;
      hwMode <= hwN;
      firstWord <= firstN;
      errQ <= errN;
    end
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_DONE);
  assign fail = done && errQ;

endmodule

// File: rtl/aai_word_prog.sv
module aai_word_prog
  import aai_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int POLL_W = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic start,
  input  logic [23:0] startAddr,
  input  logic [CNT_W-1:0] wordCount,
  input  logic hwReady,
  input  logic [POLL_W-1:0] pollLimit,
  input  logic [15:0] wordData,
  input  logic wordValid,
  output logic wordReady,
  output logic sck,
  output logic csN,
  output logic mosi,
  input  logic miso,
  output logic busy,
  output logic done,
  output logic fail
);

  dpCtrlT ctl;
  logic byteDone, rxBusy, wordsLeftZero, pollExhausted;

  aai_control i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .hwReady(hwReady),
    .addrOdd(startAddr[0]), .countZero(wordCount == '0),
    .wordValid(wordValid), .miso(miso), .byteDone(byteDone),
    .rxBusy(rxBusy), .wordsLeftZero(wordsLeftZero),
    .pollExhausted(pollExhausted), .ctl(ctl), .wordReady(wordReady),
    .busy(busy), .done(done), .fail(fail)
  );

  aai_datapath #(.CNT_W(CNT_W), .POLL_W(POLL_W)) i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .startAddr(startAddr),
    .wordCount(wordCount), .pollLimit(pollLimit), .wordData(wordData),
    .miso(miso), .sck(sck), .csN(csN), .mosi(mosi), .byteDone(byteDone),
    .rxBusy(rxBusy), .wordsLeftZero(wordsLeftZero),
    .pollExhausted(pollExhausted)
  );

endmodule

// File: rtl/aai_word_prog_chk.sv
module aai_word_prog_chk #(
  parameter int CNT_W = 16,
  parameter int POLL_W = 16
) (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic [23:0] startAddr,
  input logic [CNT_W-1:0] wordCount,
  input logic hwReady,
  input logic [POLL_W-1:0] pollLimit,
  input logic [15:0] wordData,
  input logic wordValid,
  input logic wordReady,
  input logic sck,
  input logic csN,
  input logic mosi,
  input logic miso,
  input logic busy,
  input logic done,
  input logic fail
);

  // R8
  sck_idle_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sck);

  // R8
  sck_rise_selected_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sck) |-> !csN);

  // R1
  reject_bad_job_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && (startAddr[0] || wordCount == '0)) |=> (done && fail));

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy));

  // R9
  ready_in_job_chk: assert property (@(posedge clk) disable iff (!rstN)
    wordReady |-> busy);

  // R9
  one_word_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wordReady && wordValid) |=> !wordReady);

endmodule

bind aai_word_prog aai_word_prog_chk #(.CNT_W(CNT_W), .POLL_W(POLL_W)) i_chk (.*);

// File: tb/test_aai_word_prog.sv
`timescale 1ns/1ps
module test_aai_word_prog;

  localparam int CNT_W = 16;
  localparam int POLL_W = 16;
  localparam int MEM_N = 512;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [23:0] startAddr = '0;
  logic [CNT_W-1:0] wordCount = '0;
  logic hwReady = 1'b0;
  logic [POLL_W-1:0] pollLimit = '0;
  logic [15:0] wordData = '0;
  logic wordValid = 1'b0;
  logic wordReady, sck, csN, mosi, miso, busy, done, fail;

  always #4 clk = ~clk;

  aai_word_prog #(.CNT_W(CNT_W), .POLL_W(POLL_W)) i_aai_word_prog (
    .clk(clk), .rstN(rstN), .start(start), .startAddr(startAddr),
    .wordCount(wordCount), .hwReady(hwReady), .pollLimit(pollLimit),
    .wordData(wordData), .wordValid(wordValid), .wordReady(wordReady),
    .sck(sck), .csN(csN), .mosi(mosi), .miso(miso), .busy(busy),
    .done(done), .fail(fail)
  );

  // ---------------- behavioural flash ----------------
  bit clrReq = 0, stuck = 0;
  int busyMax = 0;
  bit prevSck = 0, prevCs = 1, busyAtOpen = 0;
  int bitCnt = 0, busyCnt = 0, curAddr = 0, aaiStart = -1;
  logic [7:0] frameBuf [8];
  logic [7:0] mem [MEM_N];
  bit wel = 0, aai = 0, hwSo = 0, gotOp = 0;
  int viol = 0, csFalls = 0;
  int wrenCnt = 0, wrdiCnt = 0, progCnt = 0, statCnt = 0, ryonCnt = 0, ryoffCnt = 0;
  logic [7:0] firstOp = 0, lastOp = 0, prevOp = 0;

  wire statusBusy = (busyCnt != 0) || (stuck && aai);
  wire [7:0] statusByte = {1'b0, aai, 4'b0000, wel, statusBusy};

  assign miso = (!csN && hwSo && aai) ? !statusBusy :
                (!csN && frameBuf[0] == 8'h05 && bitCnt >= 8 && bitCnt < 16) ?
                statusByte[15 - bitCnt] : 1'b0;

  task automatic putWord(input int hiIdx);
    mem[curAddr % MEM_N] = frameBuf[hiIdx];
    mem[(curAddr + 1) % MEM_N] = frameBuf[hiIdx + 1];
    curAddr += 2;
  endtask

  task automatic endFrame();
    int nb;
    logic [7:0] op;
    nb = bitCnt / 8;
    op = frameBuf[0];
    if (bitCnt == 0) begin
      if (!(hwSo && aai)) viol++;
    end else if (bitCnt % 8 != 0) viol++;
    else begin
      if (!gotOp) firstOp = op;
      gotOp = 1;
      prevOp = lastOp;
      lastOp = op;
      case (op)
        8'h06: begin wel = 1; wrenCnt++; end
        8'h04: begin wel = 0; aai = 0; wrdiCnt++; end
        8'h70: begin hwSo = 1; ryonCnt++; end
        8'h80: begin hwSo = 0; ryoffCnt++; end
        8'h05: begin statCnt++; if (nb < 2) viol++; end
        8'hAD: begin
          progCnt++;
          if (busyAtOpen) viol++;
          if (!aai) begin
            if (!wel || nb != 6 || frameBuf[3][0]) viol++;
            else begin
              aaiStart = {8'h00, frameBuf[1], frameBuf[2], frameBuf[3]};
              curAddr = aaiStart;
              aai = 1;
              putWord(4);
            end
          end else if (nb != 3) viol++;
          else putWord(1);
          busyCnt = $urandom_range(busyMax, 0);
        end
        default: viol++;
      endcase
    end
  endtask

  always @(posedge clk) begin
    if (clrReq) begin
      wel = 0; aai = 0; hwSo = 0; gotOp = 0; viol = 0; csFalls = 0;
      wrenCnt = 0; wrdiCnt = 0; progCnt = 0; statCnt = 0; ryonCnt = 0; ryoffCnt = 0;
      firstOp = 0; lastOp = 0; prevOp = 0; busyCnt = 0; aaiStart = -1; bitCnt = 0;
      for (int i = 0; i < MEM_N; i++) mem[i] = 8'h00;
    end else begin
      if (busyCnt > 0) busyCnt--;
      if (prevCs && !csN) begin
        bitCnt = 0;
        csFalls++;
        busyAtOpen = statusBusy;
      end
      if (!csN && sck && !prevSck) begin
        if (bitCnt < 64) frameBuf[bitCnt / 8] = {frameBuf[bitCnt / 8][6:0], mosi};
        bitCnt++;
      end
      if (csN && !prevCs) endFrame();
    end
    prevCs = csN;
    prevSck = sck;
  end

  // ---------------- checking ----------------
  int nChecks = 0, nFail = 0;
  logic [15:0] wData [64];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int memErrors(input int addr, input int cnt);
    int e = 0;
    for (int i = 0; i < cnt; i++) begin
      if (mem[(addr + 2 * i) % MEM_N] !== wData[i][15:8]) e++;
      if (mem[(addr + 2 * i + 1) % MEM_N] !== wData[i][7:0]) e++;
    end
    return e;
  endfunction

  task automatic runJob(input logic [23:0] addr, input int cnt, input bit hw,
                        input int limit, input int bmax, input bit stk);
    bit expReject, expFail, hs, gotFail;
    int taken, idx, cyc;
    expReject = addr[0] || (cnt == 0);
    expFail = expReject || stk;
    hs = 0; gotFail = 0; taken = 0; idx = 0; cyc = 0;
    stuck = stk;
    busyMax = bmax;
    for (int i = 0; i < cnt; i++) wData[i] = 16'($urandom);
    @(negedge clk);
    clrReq = 1;
    startAddr = addr;
    wordCount = CNT_W'(cnt);
    hwReady = hw;
    pollLimit = POLL_W'(limit);
    start = 1;
    @(negedge clk);
    clrReq = 0;
    start = 0;
    // R10: busy right after the start edge
    chk(busy === 1'b1, "R10", "busy after start", busy, 1);
    while (1) begin
      if (done) begin
        gotFail = fail;
        break;
      end
      cyc++;
      if (cyc > 60000) begin
        chk(0, "R10", "watchdog expired", cyc, 60000);
        break;
      end
      if (hs) begin
        idx++;
        taken++;
      end
      wordValid = (idx < cnt) && ($urandom_range(3, 0) != 0);
      wordData = wordValid ? wData[idx] : 16'($urandom);
      hs = wordValid && wordReady;
      @(negedge clk);
    end
    wordValid = 0;
    @(negedge clk);
    chk(!busy && !done, "R10", "idle after done", {busy, done}, 0);
    chk(gotFail == expFail, expReject ? "R1" : (stk ? "R7" : "R6"),
        "fail flag", gotFail, expFail);
    if (expReject) begin
      chk(csFalls == 0, "R1", "chip selects on rejected job", csFalls, 0);
      chk(taken == 0, "R1", "words taken on rejected job", taken, 0);
      return;
    end
    chk(viol == 0, hw ? "R5" : "R4", "flash protocol violations", viol, 0);
    chk(wrenCnt == 1 && firstOp == (hw ? 8'h70 : 8'h06), "R2",
        "first opcode", firstOp, hw ? 8'h70 : 8'h06);
    chk(aaiStart == int'(addr), "R3", "program start address", aaiStart, addr);
    chk(taken == (stk ? 1 : cnt), "R9", "words taken", taken, stk ? 1 : cnt);
    chk(progCnt == (stk ? 1 : cnt), "R9", "program frames", progCnt, stk ? 1 : cnt);
    if (!stk) chk(memErrors(addr, cnt) == 0, "R3", "flash byte mismatches",
                  memErrors(addr, cnt), 0);
    if (hw) begin
      chk(statCnt == 0, "R5", "status frames in ready-output mode", statCnt, 0);
      chk(prevOp == 8'h04 && lastOp == 8'h80, "R6", "closing opcodes",
          {prevOp, lastOp}, 16'h0480);
    end else begin
      chk(lastOp == 8'h04, "R6", "closing opcode", lastOp, 8'h04);
      if (stk) chk(statCnt == limit, "R7", "status polls before timeout", statCnt, limit);
      else chk(statCnt >= cnt, "R4", "status polls", statCnt, cnt);
    end
    chk(!wel && !aai && !hwSo, stk ? "R7" : "R6", "flash left in normal state",
        {wel, aai, hwSo}, 0);
  endtask

  initial begin
    int wd;
    void'($urandom(32'd2024));
    wd = 0;
    #20;
    chk(csN === 1'b1 && sck === 1'b0, "R8", "reset bus state", {csN, sck}, 2);
    chk(!busy && !done && !wordReady, "R10", "reset status", {busy, done, wordReady}, 0);
    @(negedge clk);
    rstN = 1;
    @(negedge clk);
    runJob(24'h000101, 4, 0, 100, 5, 0);    // R1 odd address
    runJob(24'h000100, 0, 1, 100, 5, 0);    // R1 zero count
    runJob(24'h012340, 1, 0, 1000, 6, 0);   // R4 single word polled
    runJob(24'h0000F0, 1, 1, 1000, 0, 0);   // R5 ready immediately
    runJob(24'h000020, 3, 0, 3, 5, 1);      // R7 polling timeout
    runJob(24'h000040, 2, 1, 20, 5, 1);     // R7 ready-output timeout
    runJob(24'h03FFE0, 12, 1, 1000, 30, 0); // R3 longer run
    for (int j = 0; j < 6; j++) begin
      runJob({$urandom_range(255, 0), 8'h00, 7'($urandom_range(100, 0)), 1'b0},
             $urandom_range(12, 1), 1'($urandom_range(1, 0)), 1000,
             $urandom_range(40, 0), 0);
    end
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule